// File: doc/BRIEF.md
# Peak-Holding Negative Slope Detector

This block watches a battery voltage that has been turned into a pulse rate, and reports when that voltage has started to fall. Each measurement window is framed by the sample sequencer. A load strobe clears the sample counter and copies the highest count seen so far into a comparison reference. A gate strobe then lets the frequency pulses into the counter. A one-cycle end strobe closes the window, and on that strobe the new count is compared with the reference.

The stored peak only ever moves upward. A sample above the reference becomes the new peak. A sample at least two counts below the reference is a drop event. When two drop events come back to back, the detection flag is raised, and it stays high until reset. A sample that is neither above the reference nor far enough below it clears a pending drop event. The mode controller gates the detection flag with its own holdoff time.

Top module: `peak_slope_detector`

## Requirements
- R1: While reset is held, and right after it, `detectOut` and `pendingOut` are 0 and `peakOut` is 0.
- R2: A pulse on `pulseIn` is counted only when `gateIn` is high. Pulses that arrive while the gate is low, including those during the end strobe, leave the compared sample unchanged.
- R3: The sample counter saturates at 1023. A window that holds more pulses yields a sample of 1023.
- R4: While `loadIn` is high, the sample counter is held at zero and the reference takes the current peak. This holds even when `gateIn` and `pulseIn` are high at the same time.
- R5: On the end strobe, a sample larger than the reference is written into `peakOut` and `pendingOut` goes to 0. The first sample after reset always becomes the peak.
- R6: A sample that is two or more counts below the reference is a drop event and sets `pendingOut` to 1. A sample exactly one count below the reference is not a drop event.
- R7: A drop event while `pendingOut` is 1 sets `detectOut` to 1. `detectOut` then stays 1 until reset, whatever samples follow.
- R8: On the end strobe, a sample equal to the reference or one count below it sets `pendingOut` to 0 and leaves `peakOut` unchanged.
- R9: A pulse in the same cycle as the end strobe, with `gateIn` still high, is included in the sample being compared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| pulseIn | input | 1 | Frequency pulse, one cycle wide, synchronous to clk |
| loadIn | input | 1 | Window start: clear the counter and load the reference from the peak |
| gateIn | input | 1 | Counting window: pulses are counted while high |
| endIn | input | 1 | One-cycle strobe: compare the sample and update the state |
| detectOut | output | 1 | Sticky negative slope detection flag |
| pendingOut | output | 1 | A drop event is waiting for its successor |
| peakOut | output | 10 | Highest sample seen since reset |

## Verification
Two functions can fall in the same clock cycle: the last count increment of a window and the comparison triggered by the end strobe. The bench provokes this by raising `pulseIn` together with `endIn` while `gateIn` is still high. It then expects the peak to equal the full pulse count, not one less. It also raises the end strobe with a stray pulse after the gate has fallen, and loads with the gate and pulses active, to confirm that those pulses change no compared sample.

// File: rtl/slope_det_pkg.sv
package slope_det_pkg;

  typedef struct packed {
    logic clearCnt;
    logic loadRef;
    logic countEn;
    logic compare;
  } strobe_t;

endpackage

// File: rtl/psd_control.sv
module psd_control
  import slope_det_pkg::*;
#(
  parameter int DROP_RUN = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    pulseIn,
  input  logic    loadIn,
  input  logic    gateIn,
  input  logic    endIn,
  input  logic    dropIn,
  output strobe_t strb,
  output logic    detectOut,
  output logic    pendingOut
);

  localparam int RUN_W = $clog2(DROP_RUN + 1);

  logic [RUN_W-1:0] runCnt;
  logic             detectReg;

  // load has priority over the counting gate
  always_comb begin
    strb.clearCnt = loadIn;
    strb.loadRef  = loadIn;
    strb.countEn  = gateIn && pulseIn && !loadIn;
    strb.compare  = endIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runCnt    <= '0;
      detectReg <= 1'b0;
    end else if (strb.compare) begin
      if (dropIn) begin
        if (int'(runCnt) < DROP_RUN) runCnt <= runCnt + 1'b1;
        if (int'(runCnt) + 1 >= DROP_RUN) detectReg <= 1'b1;
      end else begin
        runCnt <= '0;
      end
    end
  end

  assign detectOut  = detectReg;
  assign pendingOut = (runCnt != '0);

  // R7: once raised, detection never falls outside reset
  p_detect_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    detectReg |=> detectReg);

  // R7: detection only rises out of a drop on an already pending run
  p_detect_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!detectReg && strb.compare && dropIn && runCnt == '0 && DROP_RUN > 1) |=> !detectReg);

  // R8: a compare with no drop leaves nothing pending
  p_run_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.compare && !dropIn) |=> !pendingOut);

  // R6: a drop always leaves a pending run
  p_run_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.compare && dropIn) |=> pendingOut);

endmodule

// File: rtl/psd_datapath.sv
module psd_datapath
  import slope_det_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int DROP_MIN = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  output logic             dropOut,
  output logic [CNT_W-1:0] peakOut
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] GAP_MIN = CNT_W'(DROP_MIN);

  logic [CNT_W-1:0] cntReg, cntNext, refReg, peakReg;
  logic             isAbove, isDrop;

  // next count is also the compared sample, so a pulse coinciding with the end strobe is included
  always_comb begin
    cntNext = cntReg;
    if (strb.clearCnt)                          cntNext = '0;
    else if (strb.countEn && cntReg != CNT_MAX) cntNext = cntReg + 1'b1;
  end

  always_comb begin
    isAbove = cntNext > refReg;
    isDrop  = (refReg >= cntNext) && ((refReg - cntNext) >= GAP_MIN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntReg  <= '0;
      refReg  <= '0;
      peakReg <= '0;
    end else begin
      cntReg <= cntNext;
      if (strb.loadRef) refReg <= peakReg;
      if (strb.compare && isAbove) peakReg <= cntNext;
    end
  end

  assign dropOut = strb.compare && isDrop;
  assign peakOut = peakReg;

  // R3: a full counter does not wrap
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cntReg == CNT_MAX && !strb.clearCnt) |=> cntReg == CNT_MAX);

  // R4: load forces the counter to zero
  p_load_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearCnt |=> cntReg == '0);

  // R2: without an enable or clear the count holds
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clearCnt && !strb.countEn) |=> $stable(cntReg));

  // R5: the peak only moves on a compare, and never downward
  p_peak_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.compare |=> $stable(peakReg));
  p_peak_mono_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.compare |=> peakReg >= $past(peakReg));

endmodule

// File: rtl/peak_slope_detector.sv
module peak_slope_detector
  import slope_det_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int DROP_MIN = 2,
  parameter int DROP_RUN = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pulseIn,
  input  logic             loadIn,
  input  logic             gateIn,
  input  logic             endIn,
  output logic             detectOut,
  output logic             pendingOut,
  output logic [CNT_W-1:0] peakOut
);

  strobe_t strb;
  logic    dropSig;

  psd_control #(.DROP_RUN(DROP_RUN)) uCtrl (
    .clk(clk), .rstN(rstN), .pulseIn(pulseIn), .loadIn(loadIn),
    .gateIn(gateIn), .endIn(endIn), .dropIn(dropSig), .strb(strb),
    .detectOut(detectOut), .pendingOut(pendingOut)
  );

  psd_datapath #(.CNT_W(CNT_W), .DROP_MIN(DROP_MIN)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .dropOut(dropSig), .peakOut(peakOut)
  );

endmodule

// File: tb/peak_slope_detector_test.sv
module peak_slope_detector_test;

  typedef struct {
    int    peak;
    bit    det;
    bit    pend;
    string req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pulseIn = 1'b0, loadIn = 1'b0, gateIn = 1'b0, endIn = 1'b0;
  logic       detectOut, pendingOut;
  logic [9:0] peakOut;

  int   total = 0, bad = 0;
  bit   finished = 1'b0;
  exp_t expQ[$];
  event doneEv;

  int mPeak = 0, mRun = 0;
  bit mDet = 1'b0;

  always #2.5 clk = ~clk;

  peak_slope_detector uut (
    .clk(clk), .rstN(rstN), .pulseIn(pulseIn), .loadIn(loadIn),
    .gateIn(gateIn), .endIn(endIn), .detectOut(detectOut),
    .pendingOut(pendingOut), .peakOut(peakOut)
  );

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void modelSample(int n);
    int c = (n > 1023) ? 1023 : n;
    if (c > mPeak) begin
      mPeak = c; mRun = 0;
    end else if (mPeak - c >= 2) begin
      if (mRun >= 1) mDet = 1'b1;
      if (mRun < 2) mRun++;
    end else begin
      mRun = 0;
    end
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", "detect in reset", int'(detectOut), 0);
    check("R1", "peak in reset", int'(peakOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "pending after reset", int'(pendingOut), 0);
    check("R1", "detect after reset", int'(detectOut), 0);
    mPeak = 0; mRun = 0; mDet = 1'b0;
  endtask

  // one measurement window; coincide puts the last pulse on the end strobe (R9),
  // strays injects pulses outside the gate and during load (R2, R4)
  task automatic doSample(int n, bit coincide, bit strays, string req);
    exp_t e;
    modelSample(n);
    e.peak = mPeak; e.det = mDet; e.pend = (mRun != 0); e.req = req;
    expQ.push_back(e);
    if (strays) begin
      gateIn = 1'b0;
      for (int k = 0; k < 5; k++) begin
        pulseIn = 1'b1; @(negedge clk);
      end
    end
    loadIn = 1'b1; gateIn = strays; pulseIn = strays;
    repeat (2) @(negedge clk);
    loadIn = 1'b0; gateIn = 1'b1; pulseIn = 1'b0;
    @(negedge clk);
    for (int k = 0; k < (coincide ? n - 1 : n); k++) begin
      pulseIn = 1'b1; @(negedge clk);
    end
    if (coincide) begin
      pulseIn = 1'b1; endIn = 1'b1;
      @(negedge clk);
      pulseIn = 1'b0; endIn = 1'b0; gateIn = 1'b0;
    end else begin
      gateIn = 1'b0; pulseIn = 1'b0;
      @(negedge clk);
      endIn = 1'b1; pulseIn = strays;
      @(negedge clk);
      endIn = 1'b0; pulseIn = 1'b0;
    end
    ->doneEv;
    @(negedge clk);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(doneEv);
      if (expQ.size() == 0) begin
        check("R5", "scoreboard empty", 1, 0);
      end else begin
        e = expQ.pop_front();
        check(e.req, "peak", int'(peakOut), e.peak);
        check(e.req, "detect", int'(detectOut), int'(e.det));
        check(e.req, "pending", int'(pendingOut), int'(e.pend));
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    doReset();
    doSample(100, 1'b0, 1'b0, "R5");  // first sample becomes peak
    doSample(99,  1'b0, 1'b0, "R6");  // one below: not a drop
    doSample(98,  1'b0, 1'b0, "R6");  // two below: drop pending
    doSample(100, 1'b0, 1'b0, "R8");  // equal: clears pending
    doSample(98,  1'b0, 1'b0, "R6");
    doSample(120, 1'b0, 1'b0, "R5");  // new peak clears pending
    doSample(118, 1'b0, 1'b0, "R6");
    doSample(110, 1'b0, 1'b0, "R7");  // second drop: detect
    doSample(200, 1'b0, 1'b0, "R7");  // sticky despite rise
    doSample(130, 1'b0, 1'b0, "R7");
    doReset();
    doSample(50,   1'b1, 1'b0, "R9");   // coinciding pulse counted
    doSample(60,   1'b0, 1'b1, "R2");   // stray pulses ignored
    doSample(59,   1'b0, 1'b1, "R4");   // load with gate active still clears
    doSample(1100, 1'b0, 1'b0, "R3");   // saturates at 1023
    doSample(1021, 1'b1, 1'b0, "R9");   // drop of two with coinciding pulse
    doSample(1022, 1'b0, 1'b0, "R8");   // one below clears pending
    doSample(1021, 1'b0, 1'b0, "R6");
    doSample(1000, 1'b0, 1'b0, "R7");
    repeat (3) @(negedge clk);
    check("R5", "scoreboard drained", expQ.size(), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule